// File: doc/BRIEF.md
# Packed Unpack Interleave Unit

This block merges two 64-bit packed operands, a destination and a source, by taking the elements from one half of each and interleaving them. The interleaved elements are twice the width of the inputs. An 8-bit opcode chooses the element size (byte, word or dword) and the half (lower or upper). The source operand reaches the block already fetched, from a register or from memory. The block does not decode addressing or write any result back.

Each operation passes through two register stages. The first stage decodes the opcode and keeps only the selected halves of the two operands. The second stage shuffles those halves and registers the result. The unit accepts a new operation every cycle. It flags any opcode outside its set of six as illegal and returns a zero result for it.

Top module: `pkunpack_unit`

## Requirements
- R1: Opcode 0x60 interleaves bytes from bits 31:0. Result word i (bits 16i+15:16i) is {source byte i, destination byte i}, with the destination byte in the lower 8 bits.
- R2: Opcode 0x61 interleaves words from bits 31:0. Result dword i (bits 32i+31:32i) is {source word i, destination word i}, with the destination word in the lower 16 bits.
- R3: Opcode 0x62 returns {source bits 31:0, destination bits 31:0}, with the destination in result bits 31:0.
- R4: Opcodes 0x68, 0x69 and 0x6A do the same as 0x60, 0x61 and 0x62, but take their elements from bits 63:32 of both operands.
- R5: out_valid rises exactly two rising clock edges after in_valid is sampled high. It stays low at the first edge and after the second edge unless a new operation follows. Operations presented on consecutive cycles come out on consecutive cycles, in the same order.
- R6: Any opcode other than the six above gives out_valid together with out_illegal, and out_result is zero.
- R7: While out_valid is low, out_result is zero and out_illegal is low. An input with in_valid low produces no output, whatever its opcode and data.
- R8: An active-low asynchronous reset (rst_n) clears both stages at once. out_valid, out_illegal and out_result read zero while rst_n is low, and no operation that was in flight comes out after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks an operation on the input side this cycle |
| in_opcode | input | 8 | Second opcode byte that selects the unpack form |
| in_dst | input | 64 | Destination operand; its elements fill the lower part of each result element |
| in_src | input | 64 | Source operand, from a register or memory; its elements fill the upper part |
| out_valid | output | 1 | Result present, two cycles after the input |
| out_result | output | 64 | Interleaved result; zero when idle or illegal |
| out_illegal | output | 1 | Opcode was not one of the six unpack forms |

## Verification
Every result, including an illegal-opcode flag, becomes visible after the second rising edge that follows the input. The vector table is therefore streamed one entry per cycle, and each entry is compared at the falling edge two cycles after it was driven. This also proves the unit accepts back-to-back operations with no bubbles. Directed cases sample single pulses at the falling edges one, two and three cycles after input, to show the result appears in exactly one cycle. The asynchronous reset is checked a fraction of a cycle after it is applied, with no clock edge in between.

// File: rtl/pkunpack_pkg.sv
package pkunpack_pkg;

   // Opcode values; the bit pattern carries size (low bits) and half (bit 3)
   localparam logic [7:0] OPC_LO_BW = 8'h60;
   localparam logic [7:0] OPC_LO_WD = 8'h61;
   localparam logic [7:0] OPC_LO_DQ = 8'h62;
   localparam logic [7:0] OPC_HI_BW = 8'h68;
   localparam logic [7:0] OPC_HI_WD = 8'h69;
   localparam logic [7:0] OPC_HI_DQ = 8'h6A;

   localparam int NUM_ESIZE = 3;

   typedef enum logic [1:0] {
      ESZ_BYTE  = 2'd0,
      ESZ_WORD  = 2'd1,
      ESZ_DWORD = 2'd2
   } esize_e;

   typedef struct packed {
      logic   legal;
      logic   upper;
      esize_e esize;
   } unpk_ctl_t;

endpackage

// File: rtl/pkunpack_decode.sv
module pkunpack_decode
   import pkunpack_pkg::*;
#(
   parameter int OPC_W = 8
) (
   input  logic [OPC_W-1:0] opcode,
   output unpk_ctl_t        ctl
);

   generate
      if (OPC_W != 8) begin : g_bad_opc_w
         $error("pkunpack_decode: OPC_W must be 8");
      end
   endgenerate

   always_comb begin
      ctl = '{legal: 1'b0, upper: 1'b0, esize: ESZ_BYTE};
      case (opcode)
         OPC_LO_BW: ctl = '{legal: 1'b1, upper: 1'b0, esize: ESZ_BYTE};
         OPC_LO_WD: ctl = '{legal: 1'b1, upper: 1'b0, esize: ESZ_WORD};
         OPC_LO_DQ: ctl = '{legal: 1'b1, upper: 1'b0, esize: ESZ_DWORD};
         OPC_HI_BW: ctl = '{legal: 1'b1, upper: 1'b1, esize: ESZ_BYTE};
         OPC_HI_WD: ctl = '{legal: 1'b1, upper: 1'b1, esize: ESZ_WORD};
         OPC_HI_DQ: ctl = '{legal: 1'b1, upper: 1'b1, esize: ESZ_DWORD};
         default:   ctl = '{legal: 1'b0, upper: 1'b0, esize: ESZ_BYTE};
      endcase
   end

endmodule

// File: rtl/pkunpack_halfsel.sv
module pkunpack_halfsel #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0]   word_in,
   input  logic                upper,
   output logic [DATA_W/2-1:0] half_out
);

   localparam int HALF_W = DATA_W / 2;

   generate
      if (DATA_W % 2 != 0) begin : g_bad_data_w
         $error("pkunpack_halfsel: DATA_W must be even");
      end
   endgenerate

   assign half_out = upper ? word_in[DATA_W-1:HALF_W] : word_in[HALF_W-1:0];

endmodule

// File: rtl/pkunpack_interleave.sv
module pkunpack_interleave #(
   parameter int HALF_W = 32,
   parameter int ELEM_W = 8
) (
   input  logic [HALF_W-1:0]   lo_half,
   input  logic [HALF_W-1:0]   hi_half,
   output logic [2*HALF_W-1:0] merged
);

   localparam int N_ELEM = HALF_W / ELEM_W;

   generate
      if (HALF_W % ELEM_W != 0) begin : g_bad_elem_w
         $error("pkunpack_interleave: HALF_W must be a multiple of ELEM_W");
      end
      for (genvar i = 0; i < N_ELEM; i++) begin : g_elem
         assign merged[(2*i)*ELEM_W   +: ELEM_W] = lo_half[i*ELEM_W +: ELEM_W];
         assign merged[(2*i+1)*ELEM_W +: ELEM_W] = hi_half[i*ELEM_W +: ELEM_W];
      end
   endgenerate

endmodule

// File: rtl/pkunpack_unit.sv
module pkunpack_unit
   import pkunpack_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 8,
   parameter int OPC_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [OPC_W-1:0]        in_opcode,
   input  logic [BYTE_W*LANES-1:0] in_dst,
   input  logic [BYTE_W*LANES-1:0] in_src,
   output logic                    out_valid,
   output logic [BYTE_W*LANES-1:0] out_result,
   output logic                    out_illegal
);

   localparam int DATA_W = BYTE_W * LANES;
   localparam int HALF_W = DATA_W / 2;

   generate
      if (LANES < 8 || LANES % 8 != 0) begin : g_bad_lanes
         $error("pkunpack_unit: LANES must be a multiple of 8");
      end
      if (BYTE_W < 1) begin : g_bad_byte_w
         $error("pkunpack_unit: BYTE_W must be positive");
      end
   endgenerate

   // ---------------- stage 1: decode and half selection ----------------
   unpk_ctl_t          dec_ctl;
   logic [HALF_W-1:0]  dst_half;
   logic [HALF_W-1:0]  src_half;

   pkunpack_decode #(.OPC_W(OPC_W)) decode_i (
      .opcode (in_opcode),
      .ctl    (dec_ctl)
   );

   pkunpack_halfsel #(.DATA_W(DATA_W)) dst_sel_i (
      .word_in  (in_dst),
      .upper    (dec_ctl.upper),
      .half_out (dst_half)
   );

   pkunpack_halfsel #(.DATA_W(DATA_W)) src_sel_i (
      .word_in  (in_src),
      .upper    (dec_ctl.upper),
      .half_out (src_half)
   );

   logic              s1_valid;
   unpk_ctl_t         s1_ctl;
   logic [HALF_W-1:0] s1_dst;
   logic [HALF_W-1:0] s1_src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_ctl   <= '{legal: 1'b0, upper: 1'b0, esize: ESZ_BYTE};
         s1_dst   <= '0;
         s1_src   <= '0;
      end else begin
         s1_valid <= in_valid;
         s1_ctl   <= dec_ctl;
         s1_dst   <= dst_half;
         s1_src   <= src_half;
      end
   end

   // ---------------- stage 2: shuffle networks and result ----------------
   logic [DATA_W-1:0] shuf [NUM_ESIZE];

   generate
      for (genvar s = 0; s < NUM_ESIZE; s++) begin : g_esize
         localparam int ELEM_W = BYTE_W << s;
         pkunpack_interleave #(.HALF_W(HALF_W), .ELEM_W(ELEM_W)) ilv_i (
            .lo_half (s1_dst),
            .hi_half (s1_src),
            .merged  (shuf[s])
         );
      end
   endgenerate

   logic [DATA_W-1:0] shuf_pick;
   logic [DATA_W-1:0] res_next;

   always_comb begin
      case (s1_ctl.esize)
         ESZ_BYTE:  shuf_pick = shuf[0];
         ESZ_WORD:  shuf_pick = shuf[1];
         ESZ_DWORD: shuf_pick = shuf[2];
         default:   shuf_pick = '0;
      endcase
      res_next = (s1_valid && s1_ctl.legal) ? shuf_pick : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_illegal <= 1'b0;
         out_result  <= '0;
      end else begin
         out_valid   <= s1_valid;
         out_illegal <= s1_valid && !s1_ctl.legal;
         out_result  <= res_next;
      end
   end

endmodule

// File: rtl/pkunpack_checker.sv
module pkunpack_checker
   import pkunpack_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 8,
   parameter int OPC_W  = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic [OPC_W-1:0]        in_opcode,
   input logic [BYTE_W*LANES-1:0] in_dst,
   input logic [BYTE_W*LANES-1:0] in_src,
   input logic                    out_valid,
   input logic [BYTE_W*LANES-1:0] out_result,
   input logic                    out_illegal
);

   localparam int DATA_W = BYTE_W * LANES;
   localparam int HALF_W = DATA_W / 2;

   // Edges seen since reset release, saturating at two, so $past(x,2) is valid
   logic [1:0] warm_cnt;
   logic       warm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             warm_cnt <= 2'd0;
      else if (warm_cnt != 2) warm_cnt <= warm_cnt + 2'd1;
   end
   assign warm = (warm_cnt == 2'd2);

   logic op_known;
   assign op_known = (in_opcode == OPC_LO_BW) || (in_opcode == OPC_LO_WD) ||
                     (in_opcode == OPC_LO_DQ) || (in_opcode == OPC_HI_BW) ||
                     (in_opcode == OPC_HI_WD) || (in_opcode == OPC_HI_DQ);

   assert_low_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid && $past(in_opcode, 2) == OPC_LO_BW) |->
      out_result[2*BYTE_W-1:0] == {$past(in_src[BYTE_W-1:0], 2), $past(in_dst[BYTE_W-1:0], 2)});

   assert_low_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid && $past(in_opcode, 2) == OPC_LO_WD) |->
      out_result[4*BYTE_W-1:0] == {$past(in_src[2*BYTE_W-1:0], 2), $past(in_dst[2*BYTE_W-1:0], 2)});

   assert_low_dword_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid && $past(in_opcode, 2) == OPC_LO_DQ) |->
      out_result == {$past(in_src[HALF_W-1:0], 2), $past(in_dst[HALF_W-1:0], 2)});

   assert_high_dword_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid && $past(in_opcode, 2) == OPC_HI_DQ) |->
      out_result == {$past(in_src[DATA_W-1:HALF_W], 2), $past(in_dst[DATA_W-1:HALF_W], 2)});

   assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> (out_valid == $past(in_valid, 2)));

   assert_illegal_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid) |-> (out_illegal == !$past(op_known, 2)));

   assert_illegal_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> (out_valid && out_result == '0));

   assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_result == '0 && !out_illegal));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_clear_R8: assert (!out_valid && !out_illegal && out_result == '0);
      end
   end

endmodule

bind pkunpack_unit pkunpack_checker #(
   .BYTE_W (BYTE_W),
   .LANES  (LANES),
   .OPC_W  (OPC_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_opcode   (in_opcode),
   .in_dst      (in_dst),
   .in_src      (in_src),
   .out_valid   (out_valid),
   .out_result  (out_result),
   .out_illegal (out_illegal)
);

// File: tb/pkunpack_unit_tb.sv
`timescale 1ns/1ps
module pkunpack_unit_tb_top;

   localparam real CLK_PER   = 20.0;
   localparam int  WD_CYCLES = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_opcode = 8'h00;
   logic [63:0] in_dst = '0;
   logic [63:0] in_src = '0;
   logic        out_valid;
   logic [63:0] out_result;
   logic        out_illegal;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   pkunpack_unit dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_opcode   (in_opcode),
      .in_dst      (in_dst),
      .in_src      (in_src),
      .out_valid   (out_valid),
      .out_result  (out_result),
      .out_illegal (out_illegal)
   );

   localparam logic [63:0] D0 = 64'h8877665544332211;
   localparam logic [63:0] S0 = 64'hFFEEDDCCBBAA9988;
   localparam logic [63:0] D1 = 64'h0123456789ABCDEF;
   localparam logic [63:0] S1 = 64'hFEDCBA9876543210;

   typedef struct packed {
      logic [7:0]  opc;
      logic [63:0] dst;
      logic [63:0] src;
      logic [63:0] exp;
      logic        ill;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{8'h60, D0, S0, 64'hBB44AA3399228811, 1'b0},   // R1
      '{8'h68, D0, S0, 64'hFF88EE77DD66CC55, 1'b0},   // R4
      '{8'h61, D0, S0, 64'hBBAA443399882211, 1'b0},   // R2
      '{8'h69, D0, S0, 64'hFFEE8877DDCC6655, 1'b0},   // R4
      '{8'h62, D0, S0, 64'hBBAA998844332211, 1'b0},   // R3
      '{8'h6A, D0, S0, 64'hFFEEDDCC88776655, 1'b0},   // R4
      '{8'h60, D1, S1, 64'h768954AB32CD10EF, 1'b0},   // R1
      '{8'h61, D1, S1, 64'h765489AB3210CDEF, 1'b0},   // R2
      '{8'h6A, D1, S1, 64'hFEDCBA9801234567, 1'b0},   // R4
      '{8'h63, D0, S0, 64'h0000000000000000, 1'b1},   // R6
      '{8'h6B, D1, S1, 64'h0000000000000000, 1'b1},   // R6
      '{8'h70, D0, S0, 64'h0000000000000000, 1'b1},   // R6
      '{8'h69, D1, S1, 64'hFEDC0123BA984567, 1'b0},   // R4
      '{8'h68, D1, S1, 64'hFE01DC23BA459867, 1'b0},   // R4
      '{8'h62, D1, S1, 64'h7654321089ABCDEF, 1'b0},   // R3
      '{8'h64, D1, S1, 64'h0000000000000000, 1'b1}    // R6
   };

   function automatic string req_of(input logic [7:0] op, input logic ill);
      if (ill) return "R6";
      case (op)
         8'h60:   return "R1";
         8'h61:   return "R2";
         8'h62:   return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [7:0] op,
                        input logic [63:0] d, input logic [63:0] s);
      in_valid  = v;
      in_opcode = op;
      in_dst    = d;
      in_src    = s;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // Watchdog
   initial begin
      #(CLK_PER * WD_CYCLES);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R5 watchdog: actual=hung expected=finished");
         finish_run();
      end
   end

   initial begin
      // R8: state while reset held and right after release
      repeat (3) @(negedge clk);
      chk("R8", "valid in reset", {63'd0, out_valid}, 64'd0);
      chk("R8", "result in reset", out_result, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8", "illegal after reset", {63'd0, out_illegal}, 64'd0);

      // Table streamed one per cycle; entry k is due two edges later (R5)
      for (int k = 0; k < NV + 2; k++) begin
         @(negedge clk);
         if (k >= 2) begin
            chk("R5", $sformatf("valid vec %0d", k-2), {63'd0, out_valid}, 64'd1);
            chk(req_of(VEC[k-2].opc, VEC[k-2].ill), $sformatf("result vec %0d", k-2),
                out_result, VEC[k-2].exp);
            chk(req_of(VEC[k-2].opc, VEC[k-2].ill), $sformatf("illegal vec %0d", k-2),
                {63'd0, out_illegal}, {63'd0, VEC[k-2].ill});
         end
         if (k < NV) drive(1'b1, VEC[k].opc, VEC[k].dst, VEC[k].src);
         else        drive(1'b0, 8'h60, D0, S0);
      end

      // R7: pipeline drained, outputs idle
      @(negedge clk);
      chk("R7", "valid after drain", {63'd0, out_valid}, 64'd0);
      chk("R7", "result after drain", out_result, 64'd0);

      // R7: in_valid low with legal opcode and data produces nothing
      drive(1'b0, 8'h62, D1, S1);
      repeat (2) @(negedge clk);
      chk("R7", "valid for invalid input", {63'd0, out_valid}, 64'd0);
      chk("R7", "result for invalid input", out_result, 64'd0);
      chk("R7", "illegal for invalid input", {63'd0, out_illegal}, 64'd0);

      // R7: illegal opcode with in_valid low raises no flag
      drive(1'b0, 8'h77, D0, S0);
      repeat (2) @(negedge clk);
      chk("R7", "illegal flag without valid", {63'd0, out_illegal}, 64'd0);

      // R5: single pulse appears in exactly one cycle
      drive(1'b1, 8'h6A, D1, S1);
      @(negedge clk);
      drive(1'b0, 8'h00, '0, '0);
      chk("R5", "valid one edge after", {63'd0, out_valid}, 64'd0);
      @(negedge clk);
      chk("R5", "valid two edges after", {63'd0, out_valid}, 64'd1);
      chk("R4", "pulse result", out_result, 64'hFEDCBA9801234567);
      @(negedge clk);
      chk("R5", "valid three edges after", {63'd0, out_valid}, 64'd0);

      // R8: asynchronous reset with both stages occupied
      drive(1'b1, 8'h60, D0, S0);
      @(negedge clk);
      drive(1'b1, 8'h61, D1, S1);
      @(negedge clk);
      drive(1'b0, 8'h00, '0, '0);
      chk("R8", "valid before reset", {63'd0, out_valid}, 64'd1);
      #2 rst_n = 1'b0;
      #1;
      chk("R8", "valid cleared async", {63'd0, out_valid}, 64'd0);
      chk("R8", "result cleared async", out_result, 64'd0);
      #3 rst_n = 1'b1;
      @(negedge clk);
      chk("R8", "in-flight op dropped", {63'd0, out_valid}, 64'd0);
      chk("R8", "result stays zero", out_result, 64'd0);

      done = 1'b1;
      finish_run();
   end

endmodule